// File: doc/BRIEF.md
# Mask Prefix Marking Unit

This unit rewrites a destination mask according to where the first active set bit of a source mask lies. An element is active when its bit in a separate enable mask is 1. The unit has three marking styles. The first marks every active element that lies strictly ahead of the first active source 1. The second also marks that first 1. The third marks only the first 1. Elements that are not active keep the destination bit they already had. Bits at or above the vector length are not touched.

The three masks sit in byte-wide storages that the unit addresses directly. The source and enable storages have combinational read ports. The destination has a combinational read port and a write port on the same address, so each step is a read-modify-write of one byte. After a one-cycle start pulse the unit walks the bytes in ascending order, one per cycle. It carries a single "first active 1 seen" flag from byte to byte. When it finishes it pulses a completion flag. On success it also pulses a request to clear the start-index register. A start with a nonzero start index, or with an undefined style code, is refused: the unit pulses completion together with an exception and writes nothing.

Top module: `mask_first_unit`

## Requirements
- R1: With style code 0, an active element in range is written 1 while no earlier active element has source bit 1, and is written 0 from the first active source 1 onward, that element included.
- R2: With style code 1, an active element in range is written 1 up to and including the first active source 1, and is written 0 after it.
- R3: With style code 2, only the first active element whose source bit is 1 is written 1, and every other active element in range is written 0.
- R4: When no active element in range has source bit 1, style codes 0 and 1 write 1 to every active element in range, and style code 2 writes 0 to every active element in range.
- R5: An element whose enable bit is 0 keeps its previous destination bit.
- R6: Element i lives in byte i>>3 at bit i&7. Only indices below the vector length are processed, and destination bits at or above it keep their values, including those inside a partly covered last byte.
- R7: A start with a nonzero start index pulses done together with exception, performs no destination write and requests no start-index clear.
- R8: A start with style code 3 pulses done together with exception and performs no destination write.
- R9: After reset, done, exception, the start-index clear request and the destination write enable are all low. A successful operation ends with one cycle of done and the clear request high and exception low. A vector length of 0 completes this way with no write.
- R10: A successful operation of length vl writes exactly ceil(vl/8) bytes, at addresses 0, 1, 2, ... in consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | One-cycle request to begin; ignored while a scan runs |
| mode | input | 2 | Style code: 0 before-first, 1 including-first, 2 only-first, 3 undefined |
| vl | input | VL_W | Vector length in elements, at most VLMAX (larger values are clamped) |
| vstart | input | VL_W | Start index; must be 0 for the operation to run |
| src_addr | output | ADDR_W | Byte address into the source mask |
| src_data | input | 8 | Source mask byte at src_addr |
| en_addr | output | ADDR_W | Byte address into the enable mask |
| en_data | input | 8 | Enable mask byte at en_addr |
| dst_addr | output | ADDR_W | Byte address into the destination mask, for read and write |
| dst_rd_data | input | 8 | Current destination byte at dst_addr |
| dst_wr_en | output | 1 | Write strobe for the destination byte |
| dst_wr_data | output | 8 | New destination byte |
| done | output | 1 | One-cycle completion pulse |
| exception | output | 1 | Pulses with done when the request was refused |
| vstart_clr | output | 1 | Pulses with done on success to clear the start index |

## Verification
On every cycle, the assertions check four things. Each written byte leaves the bits at disabled positions equal to the byte read. Write addresses start at 0 and step by one. A refused request never coincides with a write. The clear request never accompanies an exception. The value of the three marking styles depends on where the first active 1 falls, possibly several bytes earlier, so only the bench scenarios can show it. Scenarios are compared against a bit-serial model of the rules. The same holds for the exact write count, the untouched tail above the vector length, and the refusal cases leaving the storage unchanged.

// File: rtl/mfu_pkg.sv
package mfu_pkg;
  localparam int LANE_W = 8;

  typedef enum logic [1:0] {
    MD_BEFORE = 2'd0,
    MD_INCL   = 2'd1,
    MD_ONLY   = 2'd2,
    MD_BAD    = 2'd3
  } mfu_mode_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_SCAN = 1'b1
  } mfu_state_e;
endpackage

// File: rtl/mfu_rst_sync.sv
module mfu_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic stage_q;
  logic out_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 1'b0;
      out_q   <= 1'b0;
    end else begin
      stage_q <= 1'b1;
      out_q   <= stage_q;
    end
  end

  assign rst_n_sync = out_q;
endmodule

// File: rtl/mfu_lane.sv
module mfu_lane
  import mfu_pkg::*;
#(
  parameter int W     = LANE_W,
  localparam int CNT_W = $clog2(W + 1)
) (
  input  mfu_mode_e        mode,
  input  logic             found_in,
  input  logic [CNT_W-1:0] nvalid,
  input  logic [W-1:0]     src,
  input  logic [W-1:0]     en,
  input  logic [W-1:0]     old,
  output logic [W-1:0]     result,
  output logic             found_out
);
  logic [W:0] seen;

  assign seen[0] = found_in;

  for (genvar j = 0; j < W; j++) begin : g_bit
    logic in_range;
    logic active;
    logic hit;
    logic mark;

    assign in_range = (CNT_W'(j) < nvalid);
    assign active   = in_range & en[j];
    assign hit      = active & src[j];
    assign seen[j+1] = seen[j] | hit;

    always_comb begin
      unique case (mode)
        MD_BEFORE: mark = ~(seen[j] | src[j]);
        MD_INCL:   mark = ~seen[j];
        MD_ONLY:   mark = ~seen[j] & src[j];
        default:   mark = old[j];
      endcase
    end

    assign result[j] = active ? mark : old[j];
  end

  assign found_out = seen[W];
endmodule

// File: rtl/mfu_ctrl.sv
module mfu_ctrl
  import mfu_pkg::*;
#(
  parameter int VLMAX = 256,
  localparam int NBYTES = VLMAX / LANE_W,
  localparam int ADDR_W = (NBYTES > 1) ? $clog2(NBYTES) : 1,
  localparam int VL_W   = $clog2(VLMAX + 1),
  localparam int CNT_W  = $clog2(LANE_W + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [1:0]       mode,
  input  logic [VL_W-1:0]  vl,
  input  logic [VL_W-1:0]  vstart,
  input  logic             found_out,
  output logic             step,
  output logic [ADDR_W-1:0] idx,
  output mfu_mode_e        mode_cur,
  output logic             found_cur,
  output logic [CNT_W-1:0] nvalid,
  output logic             done,
  output logic             exception,
  output logic             vstart_clr
);
  mfu_state_e        st_q, st_n;
  logic [ADDR_W-1:0] idx_q, idx_n;
  mfu_mode_e         mode_q, mode_n;
  logic [VL_W-1:0]   vl_q, vl_n;
  logic              found_q, found_n;
  logic              done_q, done_n;
  logic              exc_q, exc_n;
  logic              clr_q, clr_n;

  logic [VL_W-1:0]   base;
  logic [VL_W-1:0]   rem;
  logic              last;
  logic [VL_W-1:0]   vl_clamped;

  assign base       = VL_W'(idx_q) << 3;
  assign rem        = vl_q - base;
  assign last       = (rem <= VL_W'(LANE_W));
  assign vl_clamped = (vl > VL_W'(VLMAX)) ? VL_W'(VLMAX) : vl;

  always_comb begin
    if (rem >= VL_W'(LANE_W)) nvalid = CNT_W'(LANE_W);
    else                      nvalid = rem[CNT_W-1:0];
  end

  always_comb begin
    st_n    = st_q;
    idx_n   = idx_q;
    mode_n  = mode_q;
    vl_n    = vl_q;
    found_n = found_q;
    done_n  = 1'b0;
    exc_n   = 1'b0;
    clr_n   = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (start) begin
          if ((vstart != '0) || (mode == MD_BAD)) begin
            done_n = 1'b1;
            exc_n  = 1'b1;
          end else if (vl == '0) begin
            done_n = 1'b1;
            clr_n  = 1'b1;
          end else begin
            st_n    = ST_SCAN;
            idx_n   = '0;
            found_n = 1'b0;
            mode_n  = mfu_mode_e'(mode);
            vl_n    = vl_clamped;
          end
        end
      end
      ST_SCAN: begin
        found_n = found_out;
        if (last) begin
          st_n   = ST_IDLE;
          done_n = 1'b1;
          clr_n  = 1'b1;
        end else begin
          idx_n = idx_q + 1'b1;
        end
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      idx_q   <= '0;
      mode_q  <= MD_BEFORE;
      vl_q    <= '0;
      found_q <= 1'b0;
      done_q  <= 1'b0;
      exc_q   <= 1'b0;
      clr_q   <= 1'b0;
    end else begin
      st_q    <= st_n;
      idx_q   <= idx_n;
      mode_q  <= mode_n;
      vl_q    <= vl_n;
      found_q <= found_n;
      done_q  <= done_n;
      exc_q   <= exc_n;
      clr_q   <= clr_n;
    end
  end

  assign step       = (st_q == ST_SCAN);
  assign idx        = idx_q;
  assign mode_cur   = mode_q;
  assign found_cur  = found_q;
  assign done       = done_q;
  assign exception  = exc_q;
  assign vstart_clr = clr_q;
endmodule

// File: rtl/mask_first_unit.sv
module mask_first_unit
  import mfu_pkg::*;
#(
  parameter int VLMAX = 256,
  localparam int NBYTES = VLMAX / LANE_W,
  localparam int ADDR_W = (NBYTES > 1) ? $clog2(NBYTES) : 1,
  localparam int VL_W   = $clog2(VLMAX + 1),
  localparam int CNT_W  = $clog2(LANE_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [1:0]        mode,
  input  logic [VL_W-1:0]   vl,
  input  logic [VL_W-1:0]   vstart,
  output logic [ADDR_W-1:0] src_addr,
  input  logic [LANE_W-1:0] src_data,
  output logic [ADDR_W-1:0] en_addr,
  input  logic [LANE_W-1:0] en_data,
  output logic [ADDR_W-1:0] dst_addr,
  input  logic [LANE_W-1:0] dst_rd_data,
  output logic              dst_wr_en,
  output logic [LANE_W-1:0] dst_wr_data,
  output logic              done,
  output logic              exception,
  output logic              vstart_clr
);
  logic              rst_n_sync;
  logic              step;
  logic [ADDR_W-1:0] idx;
  mfu_mode_e         mode_cur;
  logic              found_cur;
  logic              found_out;
  logic [CNT_W-1:0]  nvalid;
  logic [LANE_W-1:0] lane_result;

  mfu_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  mfu_ctrl #(.VLMAX(VLMAX)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n_sync),
    .start      (start),
    .mode       (mode),
    .vl         (vl),
    .vstart     (vstart),
    .found_out  (found_out),
    .step       (step),
    .idx        (idx),
    .mode_cur   (mode_cur),
    .found_cur  (found_cur),
    .nvalid     (nvalid),
    .done       (done),
    .exception  (exception),
    .vstart_clr (vstart_clr)
  );

  mfu_lane #(.W(LANE_W)) u_lane (
    .mode      (mode_cur),
    .found_in  (found_cur),
    .nvalid    (nvalid),
    .src       (src_data),
    .en        (en_data),
    .old       (dst_rd_data),
    .result    (lane_result),
    .found_out (found_out)
  );

  assign src_addr    = idx;
  assign en_addr     = idx;
  assign dst_addr    = idx;
  assign dst_wr_en   = step;
  assign dst_wr_data = lane_result;
endmodule

// File: rtl/mfu_chk.sv
module mfu_chk #(
  parameter int ADDR_W = 5,
  parameter int W      = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] dst_addr,
  input logic [W-1:0]      dst_rd_data,
  input logic [W-1:0]      en_data,
  input logic              dst_wr_en,
  input logic [W-1:0]      dst_wr_data,
  input logic              done,
  input logic              exception,
  input logic              vstart_clr
);
  p_keep_inactive_r5: assert property (@(posedge clk) disable iff (!rst_n)
    dst_wr_en |-> (((dst_wr_data ^ dst_rd_data) & ~en_data) == '0));

  p_first_addr_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dst_wr_en) |-> (dst_addr == '0));

  p_addr_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (dst_wr_en && $past(dst_wr_en)) |-> (dst_addr == $past(dst_addr) + 1'b1));

  p_exc_no_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    exception |-> !dst_wr_en);

  p_exc_with_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    exception |-> done);

  p_clr_success_r9: assert property (@(posedge clk) disable iff (!rst_n)
    vstart_clr |-> (done && !exception));
endmodule

bind mask_first_unit mfu_chk #(.ADDR_W(ADDR_W), .W(mfu_pkg::LANE_W)) u_mfu_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .dst_addr    (dst_addr),
  .dst_rd_data (dst_rd_data),
  .en_data     (en_data),
  .dst_wr_en   (dst_wr_en),
  .dst_wr_data (dst_wr_data),
  .done        (done),
  .exception   (exception),
  .vstart_clr  (vstart_clr)
);

// File: tb/test_mask_first_unit.sv
`timescale 1ns/1ps
module test_mask_first_unit;
  localparam int VLMAX  = 256;
  localparam int NB     = VLMAX / 8;
  localparam int ADDR_W = $clog2(NB);
  localparam int VL_W   = $clog2(VLMAX + 1);

  logic              clk;
  logic              rst_n;
  logic              start;
  logic [1:0]        mode;
  logic [VL_W-1:0]   vl;
  logic [VL_W-1:0]   vstart;
  logic [ADDR_W-1:0] src_addr, en_addr, dst_addr;
  logic [7:0]        src_data, en_data, dst_rd_data, dst_wr_data;
  logic              dst_wr_en, done, exception, vstart_clr;

  logic [7:0] src_m [NB];
  logic [7:0] en_m  [NB];
  logic [7:0] dst_m [NB];
  logic [7:0] exp_m [NB];
  int         wr_cnt;
  int         n_checks;
  int         n_fail;
  logic [31:0] lfsr;

  mask_first_unit #(.VLMAX(VLMAX)) i_mask_first_unit (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .vl(vl), .vstart(vstart),
    .src_addr(src_addr), .src_data(src_data), .en_addr(en_addr), .en_data(en_data),
    .dst_addr(dst_addr), .dst_rd_data(dst_rd_data), .dst_wr_en(dst_wr_en),
    .dst_wr_data(dst_wr_data), .done(done), .exception(exception), .vstart_clr(vstart_clr)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  assign src_data    = src_m[src_addr];
  assign en_data     = en_m[en_addr];
  assign dst_rd_data = dst_m[dst_addr];

  always @(posedge clk) begin
    if (dst_wr_en) begin
      dst_m[dst_addr] <= dst_wr_data;
      wr_cnt <= wr_cnt + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic logic [31:0] nxt(input logic [31:0] s);
    return {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
  endfunction

  task automatic fill_rand();
    for (int b = 0; b < NB; b++) begin
      lfsr = nxt(lfsr); src_m[b] = lfsr[7:0] & lfsr[15:8] & lfsr[23:16];
      lfsr = nxt(lfsr); en_m[b]  = lfsr[7:0] | lfsr[15:8];
      lfsr = nxt(lfsr); dst_m[b] = lfsr[7:0];
    end
  endtask

  // Bit-serial model of the marking rules.
  task automatic model(input int md, input int vlen);
    bit seen;
    seen = 0;
    for (int b = 0; b < NB; b++) exp_m[b] = dst_m[b];
    for (int i = 0; i < vlen; i++) begin
      bit s, e, v;
      s = src_m[i >> 3][i & 7];
      e = en_m[i >> 3][i & 7];
      if (e) begin
        case (md)
          0: v = !seen && !s;
          1: v = !seen;
          default: v = !seen && s;
        endcase
        exp_m[i >> 3][i & 7] = v;
        if (s) seen = 1;
      end
    end
  endtask

  task automatic run_op(input int md, input int vlen, input int vst, input string req);
    bit want_exc;
    int n;
    want_exc = (vst != 0) || (md == 3);
    model(md, want_exc ? 0 : vlen);
    @(negedge clk);
    mode = 2'(md); vl = VL_W'(vlen); vstart = VL_W'(vst);
    wr_cnt = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    n = 0;
    while (!done && n < 400) begin
      @(negedge clk);
      n++;
    end
    chk(done, {req, " done"}, done, 1);
    chk(exception == want_exc, {req, " exception"}, exception, want_exc);
    chk(vstart_clr == !want_exc, {req, " vstart_clr"}, vstart_clr, !want_exc);
    chk(wr_cnt == (want_exc ? 0 : (vlen + 7) / 8), {req, " R10 write count"},
        wr_cnt, want_exc ? 0 : (vlen + 7) / 8);
    for (int b = 0; b < NB; b++)
      chk(dst_m[b] == exp_m[b], {req, $sformatf(" byte %0d", b)}, dst_m[b], exp_m[b]);
    @(negedge clk);
    chk(!done && !exception && !vstart_clr, {req, " R9 single-cycle done"}, done, 0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(!done && !exception && !vstart_clr && !dst_wr_en, "R9 reset outputs",
        {done, exception, vstart_clr, dst_wr_en}, 0);
  endtask

  task automatic t_before();
    fill_rand();
    run_op(0, 37, 0, "R1 before-first vl37");
    fill_rand();
    for (int b = 0; b < NB; b++) begin en_m[b] = 8'hFF; src_m[b] = 8'h00; end
    src_m[25] = 8'h01;
    run_op(0, 256, 0, "R1 before-first late hit");
  endtask

  task automatic t_incl();
    fill_rand();
    run_op(1, 37, 0, "R2 including-first vl37");
    fill_rand();
    run_op(1, 200, 0, "R2 including-first vl200");
  endtask

  task automatic t_only();
    fill_rand();
    run_op(2, 64, 0, "R3 only-first vl64");
    fill_rand();
    for (int b = 0; b < NB; b++) src_m[b] = 8'hFF;
    run_op(2, 129, 0, "R3 only-first dense");
  endtask

  task automatic t_none();
    for (int m = 0; m < 3; m++) begin
      fill_rand();
      for (int b = 0; b < NB; b++) src_m[b] = ~en_m[b];
      run_op(m, 100, 0, $sformatf("R4 no active one mode%0d", m));
    end
  endtask

  task automatic t_inactive();
    fill_rand();
    for (int b = 0; b < NB; b++) begin en_m[b] = 8'h5A; src_m[b] = 8'hA5; end
    run_op(1, 256, 0, "R5 inactive kept");
  endtask

  task automatic t_tail();
    fill_rand();
    run_op(0, 1, 0, "R6 vl1");
    fill_rand();
    for (int b = 0; b < NB; b++) begin en_m[b] = 8'hFF; src_m[b] = 8'h00; dst_m[b] = 8'h00; end
    run_op(0, 13, 0, "R6 partial byte tail");
  endtask

  task automatic t_vstart();
    fill_rand();
    run_op(0, 50, 3, "R7 nonzero vstart");
  endtask

  task automatic t_badmode();
    fill_rand();
    run_op(3, 50, 0, "R8 mode3");
  endtask

  task automatic t_vlzero();
    fill_rand();
    run_op(2, 0, 0, "R9 vl zero");
  endtask

  task automatic t_random();
    for (int k = 0; k < 12; k++) begin
      fill_rand();
      lfsr = nxt(lfsr);
      run_op(k % 3, 1 + (lfsr[15:0] % VLMAX), 0, "R10 random");
    end
  endtask

  initial begin
    n_checks = 0; n_fail = 0; lfsr = 32'hACE1_1357;
    start = 1'b0; mode = 2'd0; vl = '0; vstart = '0;
    for (int b = 0; b < NB; b++) begin src_m[b] = 0; en_m[b] = 0; dst_m[b] = 0; end
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_before();
    t_incl();
    t_only();
    t_none();
    t_inactive();
    t_tail();
    t_vstart();
    t_badmode();
    t_vlzero();
    t_random();
    $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule